// File: doc/BRIEF.md
# Erase-Block Protection Controller

This controller holds the protection state of every erase block of a flash array in registers and decides whether a program or erase aimed at a block may proceed. Software changes a block's protection with a two-cycle command: a setup code, then a confirm code that carries the target block address. A write-protect pin, active low, decides whether the strongest protection level can be left.

Each block is in one of three states: unlocked, locked or locked-down. After reset every block is locked. Lock-down holds the block locked. While the write-protect pin is low, neither the lock nor the unlock command can move a locked-down block. While the pin is high, a locked-down block behaves as a plain locked block: a fresh unlock or lock command moves it out of lock-down. The controller drives a permission vector with one bit per block, and a 2-bit status word for the block chosen on a status address input. A program or erase request aimed at a block that is not unlocked is refused with a one-cycle denial pulse.

The command sequencer has two states. SEQ_IDLE moves to SEQ_CONFIRM on a setup code; every other code leaves it in SEQ_IDLE. SEQ_CONFIRM waits through cycles without a valid command, then returns to SEQ_IDLE on the next valid command. If that command is a confirm code, the action is applied; if not, a sequence error is raised. Each block cell has three states: BLK_UNLOCKED, BLK_LOCKED and BLK_LOCKDOWN. The lock action moves a cell to BLK_LOCKED. The unlock action moves it to BLK_UNLOCKED. The lock-down action moves it to BLK_LOCKDOWN. The lock and unlock actions do not move a cell out of BLK_LOCKDOWN while the pin is low.

Top module: `blk_lock_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, every block reads status 2'b01 (locked) and its permission bit is 0.
- R2: A confirm code takes effect only as the first valid command after setup code 0x60. Cycles with cmd_valid low between the two are skipped. A confirm code with no setup before it changes nothing.
- R3: Confirm code 0x01 (lock) sets the addressed block to status 2'b01 and clears its permission bit.
- R4: Confirm code 0xD0 (unlock) sets a locked block to status 2'b00 (unlocked) and sets its permission bit.
- R5: Confirm code 0x2F (lock-down) sets the addressed block to status 2'b11 from any state, whatever the level of wp_n.
- R6: While wp_n is 0, unlock and lock commands leave a locked-down block at status 2'b11.
- R7: While wp_n is 1, unlock moves a locked-down block to 2'b00 and lock moves it to 2'b01.
- R8: After setup, a valid second command other than 0x01, 0xD0 or 0x2F raises seq_err for exactly the next cycle. It changes no block. It returns the sequencer to idle, so a following bare 0xD0 is ignored.
- R9: An op_req sampled at a clock edge gives op_deny = 1 in the following cycle when the target block is not unlocked, and op_deny = 0 when it is unlocked.
- R10: A command changes only the block it addresses. The permission bits of all other blocks stay as they were.
- R11: An address of NUM_BLK or above names no block. Commands sent to it change nothing, a status read of it returns 2'b01, and an op_req aimed at it is denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command code and address are valid in this cycle |
| cmd_code | input | 8 | Command code |
| cmd_addr | input | ADDR_W | Target block address |
| wp_n | input | 1 | Write-protect pin, active low |
| op_req | input | 1 | Program or erase request |
| op_addr | input | ADDR_W | Block targeted by the request |
| stat_addr | input | ADDR_W | Block whose status is shown |
| lock_status | output | 2 | bit0 = locked, bit1 = locked-down |
| blk_perm | output | NUM_BLK | Per-block permission to program or erase |
| op_deny | output | 1 | Request refused (one cycle after op_req) |
| seq_err | output | 1 | Bad second cycle of a command |

## Verification
The hardest condition to reach is a locked-down block that receives an unlock or lock command while wp_n is low, followed by the same command with wp_n high. Both outcomes must be seen from the same starting state. The stimulus locks down a block that was previously unlocked. With the pin held low, it sends both commands and checks the status after each. It then raises the pin and sends the same commands again. Two further cases are exercised: setup and confirm separated by idle cycles, and a bad second code followed at once by a bare unlock. These show whether the sequencer left its confirm state.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;
    localparam logic [7:0] CODE_SETUP    = 8'h60;
    localparam logic [7:0] CODE_LOCK     = 8'h01;
    localparam logic [7:0] CODE_UNLOCK   = 8'hD0;
    localparam logic [7:0] CODE_LOCKDOWN = 8'h2F;

    // Encoding is the status word: bit0 locked, bit1 locked-down
    typedef enum logic [1:0] {
        BLK_UNLOCKED = 2'b00,
        BLK_LOCKED   = 2'b01,
        BLK_LOCKDOWN = 2'b11
    } blk_state_t;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_LOCK,
        ACT_UNLOCK,
        ACT_LOCKDOWN
    } lock_act_t;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_CONFIRM
    } seq_state_t;
endpackage

// File: rtl/blk_lock_seq.sv
module blk_lock_seq
    import blk_lock_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_code,
    output lock_act_t  act,
    output logic       seq_err
);
    seq_state_t state_q, state_d;
    logic       bad_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            seq_err <= 1'b0;
        end else begin
            state_q <= state_d;
            seq_err <= bad_d;
        end
    end

    always_comb begin
        state_d = state_q;
        act     = ACT_NONE;
        bad_d   = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (cmd_valid && cmd_code == CODE_SETUP)
                    state_d = SEQ_CONFIRM;
            end
            SEQ_CONFIRM: begin
                if (cmd_valid) begin
                    state_d = SEQ_IDLE;
                    if (cmd_code == CODE_LOCK)
                        act = ACT_LOCK;
                    else if (cmd_code == CODE_UNLOCK)
                        act = ACT_UNLOCK;
                    else if (cmd_code == CODE_LOCKDOWN)
                        act = ACT_LOCKDOWN;
                    else
                        bad_d = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/blk_lock_cell.sv
module blk_lock_cell
    import blk_lock_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  lock_act_t  act,
    input  logic       sel,
    input  logic       wp_n,
    output blk_state_t state
);
    blk_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= BLK_LOCKED;
        else        state <= state_d;
    end

    always_comb begin
        state_d = state;
        if (sel) begin
            unique case (act)
                ACT_NONE:     state_d = state;
                ACT_LOCK:     if (state != BLK_LOCKDOWN || wp_n) state_d = BLK_LOCKED;
                ACT_UNLOCK:   if (state != BLK_LOCKDOWN || wp_n) state_d = BLK_UNLOCKED;
                ACT_LOCKDOWN: state_d = BLK_LOCKDOWN;
            endcase
        end
    end
endmodule

// File: rtl/blk_lock_ctrl.sv
module blk_lock_ctrl
    import blk_lock_pkg::*;
#(
    parameter int NUM_BLK = 12,
    parameter int ADDR_W  = $clog2(NUM_BLK)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [7:0]         cmd_code,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic               wp_n,
    input  logic               op_req,
    input  logic [ADDR_W-1:0]  op_addr,
    input  logic [ADDR_W-1:0]  stat_addr,
    output logic [1:0]         lock_status,
    output logic [NUM_BLK-1:0] blk_perm,
    output logic               op_deny,
    output logic               seq_err
);
    localparam int SLOTS = 1 << ADDR_W;

    lock_act_t          act;
    logic [1:0]         st_pad [SLOTS];
    logic [SLOTS-1:0]   perm_pad;
    logic [NUM_BLK-1:0] ld_vec;

    blk_lock_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .act       (act),
        .seq_err   (seq_err)
    );

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        if (i < NUM_BLK) begin : g_blk
            blk_state_t s;
            blk_lock_cell u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .act   (act),
                .sel   (cmd_addr == ADDR_W'(i)),
                .wp_n  (wp_n),
                .state (s)
            );
            assign st_pad[i]   = s;
            assign perm_pad[i] = (s == BLK_UNLOCKED);
            assign ld_vec[i]   = (s == BLK_LOCKDOWN);
        end else begin : g_none
            assign st_pad[i]   = BLK_LOCKED;
            assign perm_pad[i] = 1'b0;
        end
    end

    assign blk_perm    = perm_pad[NUM_BLK-1:0];
    assign lock_status = st_pad[stat_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) op_deny <= 1'b0;
        else        op_deny <= op_req & ~perm_pad[op_addr];
    end
endmodule

// File: rtl/blk_lock_chk.sv
module blk_lock_chk #(
    parameter int NUM_BLK = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic               wp_n,
    input logic               op_req,
    input logic               op_deny,
    input logic               seq_err,
    input logic [NUM_BLK-1:0] blk_perm,
    input logic [NUM_BLK-1:0] ld_vec
);
    assert_deny_after_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_deny |-> $past(op_req));

    assert_err_keeps_perm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> $stable(blk_perm));

    assert_err_after_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> $past(cmd_valid));

    assert_one_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(blk_perm ^ $past(blk_perm)) <= 1);

    assert_perm_needs_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(blk_perm) |-> $past(cmd_valid));

    assert_lockdown_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n |=> ((ld_vec & $past(ld_vec)) == $past(ld_vec)));
endmodule

bind blk_lock_ctrl blk_lock_chk #(.NUM_BLK(NUM_BLK)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .wp_n      (wp_n),
    .op_req    (op_req),
    .op_deny   (op_deny),
    .seq_err   (seq_err),
    .blk_perm  (blk_perm),
    .ld_vec    (ld_vec)
);

// File: tb/test_blk_lock_ctrl.sv
module test_blk_lock_ctrl;
    localparam int NB = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_code = 8'h00;
    logic [3:0]    cmd_addr = 4'd0;
    logic          wp_n = 1'b1;
    logic          op_req = 1'b0;
    logic [3:0]    op_addr = 4'd0;
    logic [3:0]    stat_addr = 4'd0;
    logic [1:0]    lock_status;
    logic [NB-1:0] blk_perm;
    logic          op_deny;
    logic          seq_err;

    blk_lock_ctrl i_blk_lock_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .wp_n(wp_n), .op_req(op_req), .op_addr(op_addr),
        .stat_addr(stat_addr), .lock_status(lock_status), .blk_perm(blk_perm),
        .op_deny(op_deny), .seq_err(seq_err)
    );

    always #10 clk = ~clk;

    typedef struct {
        string       tag;
        int          kind;
        logic [31:0] exp;
    } item_t;

    item_t      q[$];
    int         tests = 0;
    int         fails = 0;
    bit         done = 0;
    logic [1:0] mdl [NB];
    bit         mpend = 0;

    function automatic logic [31:0] perm_of_model();
        logic [31:0] v = '0;
        for (int i = 0; i < NB; i++) v[i] = (mdl[i] == 2'b00);
        return v;
    endfunction

    function automatic void push(string tag, int kind, logic [31:0] exp);
        item_t it;
        it.tag = tag; it.kind = kind; it.exp = exp;
        q.push_back(it);
    endfunction

    // Monitor: compares 5 ns after each rising edge
    always @(posedge clk) begin
        #5;
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            string nm;
            it = q.pop_front();
            case (it.kind)
                0: begin act = {30'd0, lock_status}; nm = "lock_status"; end
                1: begin act = {{(32-NB){1'b0}}, blk_perm}; nm = "blk_perm"; end
                2: begin act = {31'd0, op_deny}; nm = "op_deny"; end
                default: begin act = {31'd0, seq_err}; nm = "seq_err"; end
            endcase
            tests++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s %s actual=%0h expected=%0h", it.tag, nm, act, it.exp);
            end
        end
    end

    task automatic step(input string tag, input logic v, input logic [7:0] c,
                        input logic [3:0] a, input logic wp, input logic oq,
                        input logic [3:0] oa, input logic [3:0] sa);
        logic exp_deny, exp_err;
        @(negedge clk);
        cmd_valid = v; cmd_code = c; cmd_addr = a; wp_n = wp;
        op_req = oq; op_addr = oa; stat_addr = sa;
        exp_deny = oq && !((oa < NB) && mdl[oa] == 2'b00);
        exp_err = 1'b0;
        if (v) begin
            if (mpend) begin
                mpend = 0;
                if (c == 8'h01 || c == 8'hD0 || c == 8'h2F) begin
                    if (a < NB) begin
                        if (c == 8'h2F) mdl[a] = 2'b11;
                        else if (mdl[a] != 2'b11 || wp) mdl[a] = (c == 8'h01) ? 2'b01 : 2'b00;
                    end
                end else exp_err = 1'b1;
            end else if (c == 8'h60) mpend = 1;
        end
        @(posedge clk);
        #1;
        push(tag, 0, (sa < NB) ? {30'd0, mdl[sa]} : 32'd1);
        push(tag, 1, perm_of_model());
        push(tag, 2, {31'd0, exp_deny});
        push(tag, 3, {31'd0, exp_err});
    endtask

    task automatic idle(input string tag, input logic [3:0] sa, input logic wp);
        step(tag, 1'b0, 8'h00, 4'd0, wp, 1'b0, 4'd0, sa);
    endtask

    task automatic cmd2(input string tag, input logic [7:0] c, input logic [3:0] a,
                        input logic wp);
        step(tag, 1'b1, 8'h60, a, wp, 1'b0, 4'd0, a);
        step(tag, 1'b1, c, a, wp, 1'b0, 4'd0, a);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; cmd_valid = 0; op_req = 0;
        for (int i = 0; i < NB; i++) mdl[i] = 2'b01;
        mpend = 0;
        repeat (2) @(negedge clk);
        tests++;
        if (lock_status !== 2'b01 || blk_perm !== '0) begin
            fails++;
            $display("FAIL R1 in reset actual=%0h/%0h expected=1/0", lock_status, blk_perm);
        end
        rst_n = 1;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: all locked after reset
        for (int i = 0; i < NB; i++) idle("R1", 4'(i), 1'b1);
        // R2: bare confirm ignored; gap between setup and confirm
        step("R2", 1'b1, 8'hD0, 4'd3, 1'b1, 1'b0, 4'd0, 4'd3);
        cmd2("R4", 8'hD0, 4'd3, 1'b1);
        step("R2", 1'b1, 8'h60, 4'd4, 1'b1, 1'b0, 4'd0, 4'd4);
        idle("R2", 4'd4, 1'b1);
        idle("R2", 4'd4, 1'b1);
        step("R2", 1'b1, 8'hD0, 4'd4, 1'b1, 1'b0, 4'd0, 4'd4);
        // R9: request to unlocked and locked blocks
        step("R9", 1'b0, 8'h00, 4'd0, 1'b1, 1'b1, 4'd3, 4'd3);
        step("R9", 1'b0, 8'h00, 4'd0, 1'b1, 1'b1, 4'd5, 4'd5);
        idle("R9", 4'd5, 1'b1);
        // R3: lock an unlocked block
        cmd2("R3", 8'h01, 4'd4, 1'b1);
        // R5: lock-down under both pin levels
        cmd2("R5", 8'h2F, 4'd3, 1'b1);
        cmd2("R5", 8'h2F, 4'd6, 1'b0);
        // R6: pin low holds lock-down
        cmd2("R6", 8'hD0, 4'd3, 1'b0);
        cmd2("R6", 8'h01, 4'd3, 1'b0);
        step("R6", 1'b0, 8'h00, 4'd0, 1'b0, 1'b1, 4'd3, 4'd3);
        // R7: pin high releases lock-down
        cmd2("R7", 8'hD0, 4'd3, 1'b1);
        step("R7", 1'b0, 8'h00, 4'd0, 1'b1, 1'b1, 4'd3, 4'd3);
        cmd2("R7", 8'h2F, 4'd3, 1'b1);
        cmd2("R7", 8'h01, 4'd3, 1'b1);
        cmd2("R7", 8'hD0, 4'd6, 1'b1);
        // R8: bad second code, then bare unlock ignored
        cmd2("R8", 8'h55, 4'd2, 1'b1);
        step("R8", 1'b1, 8'hD0, 4'd2, 1'b1, 1'b0, 4'd0, 4'd2);
        cmd2("R8", 8'h60, 4'd2, 1'b1);
        step("R8", 1'b1, 8'hD0, 4'd2, 1'b1, 1'b0, 4'd0, 4'd2);
        idle("R8", 4'd2, 1'b1);
        // R10: many blocks changed one by one, vector checked each step
        for (int i = 0; i < NB; i += 2) cmd2("R10", 8'hD0, 4'(i), 1'b1);
        cmd2("R10", 8'h01, 4'd8, 1'b1);
        // R11: out-of-range addresses
        cmd2("R11", 8'hD0, 4'd13, 1'b1);
        cmd2("R11", 8'h2F, 4'd15, 1'b1);
        step("R11", 1'b0, 8'h00, 4'd0, 1'b1, 1'b1, 4'd13, 4'd14);
        // R1: reset again relocks everything
        do_reset();
        for (int i = 0; i < NB; i += 3) idle("R1", 4'(i), 1'b1);
        repeat (3) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule